// File: doc/BRIEF.md
# Luma Min-Max Edge Steepener

This block sharpens large luminance transitions in a streaming digital video pixel path. Each accepted luma sample enters a five-sample window. From that window the block forms the running minimum and maximum and a second-derivative contour centred on the middle sample. The sign of the contour, shifted by a line-width bias, picks the window maximum or the window minimum as the target for the centre sample. A steepness control then blends the centre sample toward that target. So a broad edge collapses into a steep one, while contours below a programmable threshold leave small detail untouched.

Alongside the steepened luma, the block outputs the momentary excursion of the window (maximum minus minimum) for a later peaking stage. It also outputs a selectable narrow or wide contour for that stage's use. The chroma samples are delayed by the same number of accepted samples and clocks, so U and V leave the block next to the luma sample they belong to. Samples arrive with a valid strobe. Cycles without the strobe leave the window untouched.

Top module: `lmx_steepener`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one cycle of `out_valid`, two clock edges later. When `out_valid` is low, `y_out`, `u_out`, `v_out`, `env_out` and `peak_contour` hold their previous values.
- R2: The window holds the newest accepted sample w0 and the four samples accepted before it (w1 to w4). Slots not yet filled since reset read as zero. The centre sample c is w2, the sample accepted two strobes before the newest.
- R3: `env_out` equals the maximum minus the minimum of the five window samples.
- R4: The wide contour is d = 2c - w0 - w4, and the biased contour is e = d + (line_width - 32). If e > 0 the target is the window maximum, if e < 0 the target is the window minimum, and if e = 0 the target is c.
- R5: If |d| < thresh, the target is c, whatever the sign of e.
- R6: `y_out` = c + floor((target - c) * k / 64), where k = steep, except that steep = 63 gives k = 64. With steep = 0, `y_out` equals c.
- R7: `peak_contour` (two's complement, DW+3 bits) equals d when `wide_sel` = 1. When `wide_sel` = 0 it equals the narrow contour 2c - w1 - w3. `wide_sel` has no effect on `y_out`.
- R8: `u_out` and `v_out` equal the U and V values that were accepted together with the centre sample c.
- R9: After reset, `out_valid` is low and every data output is zero.
- R10: Idle cycles between strobes of any length do not change the window or the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| y_in | input | DW | Luma sample |
| u_in | input | CW | U sample |
| v_in | input | CW | V sample |
| wide_sel | input | 1 | 1 selects the wide contour for `peak_contour`, 0 the narrow one |
| steep | input | KW | Steepness amount, 0 bypasses, all-ones is full |
| line_width | input | LWW | Line-width code, bias is code minus 32 |
| thresh | input | TW | Contour magnitude threshold |
| out_valid | output | 1 | Output sample strobe |
| y_out | output | DW | Steepened luma |
| u_out | output | CW | Delayed U |
| v_out | output | CW | Delayed V |
| env_out | output | DW | Window excursion, maximum minus minimum |
| peak_contour | output | DW+3 | Selected contour for the peaking stage, signed |

## Verification
The hardest case to reach is an exact zero biased contour that is not also suppressed by the threshold. It needs a window whose wide contour cancels the line-width bias precisely. The bench sweeps the line-width code across its range with a zero threshold. It feeds pseudo-random bursts and hand-built steps and impulses, so that d = 32 - line_width happens for several codes. Strobes are spread with irregular idle gaps, so that the window is shifted only by accepted samples.

// File: rtl/lmx_pkg.sv
package lmx_pkg;

  // second-derivative tap combination: twice the centre minus both edges
  function automatic int lmx_contour(int edge_a, int ctr, int edge_b);
    return (ctr <<< 1) - edge_a - edge_b;
  endfunction

  function automatic int lmx_abs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // signed line-width offset around the code midpoint
  function automatic int lmx_bias(int code, int half);
    return code - half;
  endfunction

  // blend centre toward target; full-scale code maps to unity gain
  function automatic int lmx_mix(int ctr, int tgt, int k, int kmax, int shift);
    int ke;
    ke = (k == kmax) ? (kmax + 1) : k;
    return ctr + (((tgt - ctr) * ke) >>> shift);
  endfunction

endpackage

// File: rtl/lmx_tapline.sv
module lmx_tapline #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int NT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic [DW-1:0]      y_in,
  input  logic [CW-1:0]      u_in,
  input  logic [CW-1:0]      v_in,
  output logic [NT*DW-1:0]   taps_flat,
  output logic [CW-1:0]      u_ctr,
  output logic [CW-1:0]      v_ctr
);
  localparam int CTR = NT / 2;
  localparam int CD  = CTR + 1;

  logic [DW-1:0] ytap [NT];
  logic [CW-1:0] utap [CD];
  logic [CW-1:0] vtap [CD];

  // R2: newest sample in slot 0, older samples move up on each strobe only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ytap[0] <= '0;
      utap[0] <= '0;
      vtap[0] <= '0;
    end else if (shift_en) begin
      ytap[0] <= y_in;
      utap[0] <= u_in;
      vtap[0] <= v_in;
    end
  end

  for (genvar i = 1; i < NT; i++) begin : g_ytap
    always_ff @(posedge clk) begin
      if (!rst_n)        ytap[i] <= '0;
      else if (shift_en) ytap[i] <= ytap[i-1];
    end
  end

  // R8: chroma shifts with luma, only as deep as the centre tap
  for (genvar i = 1; i < CD; i++) begin : g_ctap
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        utap[i] <= '0;
        vtap[i] <= '0;
      end else if (shift_en) begin
        utap[i] <= utap[i-1];
        vtap[i] <= vtap[i-1];
      end
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_flat
    assign taps_flat[i*DW +: DW] = ytap[i];
  end

  assign u_ctr = utap[CTR];
  assign v_ctr = vtap[CTR];

endmodule

// File: rtl/lmx_window.sv
module lmx_window #(
  parameter int DW  = 8,
  parameter int NT  = 5,
  parameter int CTW = DW + 3
) (
  input  logic [NT*DW-1:0]     taps_flat,
  output logic [DW-1:0]        win_min,
  output logic [DW-1:0]        win_max,
  output logic [DW-1:0]        win_ctr,
  output logic signed [CTW-1:0] cont_wide,
  output logic signed [CTW-1:0] cont_narrow
);
  import lmx_pkg::*;

  localparam int CTR = NT / 2;

  logic [DW-1:0] t [NT];

  for (genvar i = 0; i < NT; i++) begin : g_unpack
    assign t[i] = taps_flat[i*DW +: DW];
  end

  // R3: envelope extremes over every tap
  always_comb begin
    win_min = t[0];
    win_max = t[0];
    for (int i = 1; i < NT; i++) begin
      if (t[i] < win_min) win_min = t[i];
      if (t[i] > win_max) win_max = t[i];
    end
  end

  assign win_ctr = t[CTR];

  // R4 / R7: wide uses outer taps, narrow uses neighbours of the centre
  assign cont_wide   = CTW'(lmx_contour(int'(t[CTR-2]), int'(t[CTR]), int'(t[CTR+2])));
  assign cont_narrow = CTW'(lmx_contour(int'(t[CTR-1]), int'(t[CTR]), int'(t[CTR+1])));

endmodule

// File: rtl/lmx_decide.sv
module lmx_decide #(
  parameter int DW  = 8,
  parameter int KW  = 6,
  parameter int LWW = 6,
  parameter int TW  = DW + 2,
  parameter int CTW = DW + 3
) (
  input  logic signed [CTW-1:0] cont_wide,
  input  logic [DW-1:0]         win_min,
  input  logic [DW-1:0]         win_max,
  input  logic [DW-1:0]         win_ctr,
  input  logic [KW-1:0]         steep,
  input  logic [LWW-1:0]        line_width,
  input  logic [TW-1:0]         thresh,
  output logic                  pick_max,
  output logic                  pick_min,
  output logic                  below_thr,
  output logic [DW-1:0]         y_next
);
  import lmx_pkg::*;

  localparam int HALF = 1 << (LWW - 1);
  localparam int KMAX = (1 << KW) - 1;

  int d_i;
  int e_i;
  int tgt_i;
  int y_i;

  always_comb begin
    d_i       = int'(cont_wide);
    // R4: bias added before the sign test
    e_i       = d_i + lmx_bias(int'(line_width), HALF);
    // R5: small contours keep the centre sample
    below_thr = lmx_abs(d_i) < int'(thresh);
    pick_max  = !below_thr && (e_i > 0);
    pick_min  = !below_thr && (e_i < 0);
    if (pick_max)      tgt_i = int'(win_max);
    else if (pick_min) tgt_i = int'(win_min);
    else               tgt_i = int'(win_ctr);
    // R6: steepness blend
    y_i    = lmx_mix(int'(win_ctr), tgt_i, int'(steep), KMAX, KW);
    y_next = DW'(y_i);
  end

endmodule

// File: rtl/lmx_steepener.sv
module lmx_steepener #(
  parameter int DW  = 8,
  parameter int CW  = 8,
  parameter int KW  = 6,
  parameter int LWW = 6,
  parameter int TW  = DW + 2,
  parameter int CTW = DW + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DW-1:0]         y_in,
  input  logic [CW-1:0]         u_in,
  input  logic [CW-1:0]         v_in,
  input  logic                  wide_sel,
  input  logic [KW-1:0]         steep,
  input  logic [LWW-1:0]        line_width,
  input  logic [TW-1:0]         thresh,
  output logic                  out_valid,
  output logic [DW-1:0]         y_out,
  output logic [CW-1:0]         u_out,
  output logic [CW-1:0]         v_out,
  output logic [DW-1:0]         env_out,
  output logic signed [CTW-1:0] peak_contour
);
  localparam int NT = 5;

  logic [NT*DW-1:0]      taps_flat;
  logic [CW-1:0]         u_ctr, v_ctr;
  logic [DW-1:0]         win_min, win_max, win_ctr;
  logic signed [CTW-1:0] cont_wide, cont_narrow;
  logic                  pick_max, pick_min, below_thr;
  logic [DW-1:0]         y_next;
  logic                  upd_q;

  lmx_tapline #(.DW(DW), .CW(CW), .NT(NT)) u_tapline (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
    .y_in(y_in), .u_in(u_in), .v_in(v_in),
    .taps_flat(taps_flat), .u_ctr(u_ctr), .v_ctr(v_ctr)
  );

  lmx_window #(.DW(DW), .NT(NT), .CTW(CTW)) u_window (
    .taps_flat(taps_flat), .win_min(win_min), .win_max(win_max),
    .win_ctr(win_ctr), .cont_wide(cont_wide), .cont_narrow(cont_narrow)
  );

  lmx_decide #(.DW(DW), .KW(KW), .LWW(LWW), .TW(TW), .CTW(CTW)) u_decide (
    .cont_wide(cont_wide), .win_min(win_min), .win_max(win_max),
    .win_ctr(win_ctr), .steep(steep), .line_width(line_width),
    .thresh(thresh), .pick_max(pick_max), .pick_min(pick_min),
    .below_thr(below_thr), .y_next(y_next)
  );

  // R1: one registered stage after the window shift
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_q     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      upd_q     <= in_valid;
      out_valid <= upd_q;
    end
  end

  // R9: zero outputs after reset; R1: outputs hold between strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_out        <= '0;
      u_out        <= '0;
      v_out        <= '0;
      env_out      <= '0;
      peak_contour <= '0;
    end else if (upd_q) begin
      y_out        <= y_next;
      u_out        <= u_ctr;
      v_out        <= v_ctr;
      env_out      <= win_max - win_min;
      peak_contour <= wide_sel ? cont_wide : cont_narrow;
    end
  end

  p_strobe_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(upd_q));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd_q) |-> ($stable(y_out) && $stable(u_out) && $stable(env_out)));

  p_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (y_out >= $past(win_min) && y_out <= $past(win_max)));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(steep) == '0) |-> y_out == $past(win_ctr));

  p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pick_max, pick_min}));

  p_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(below_thr)) |-> y_out == $past(win_ctr));

endmodule

// File: tb/test_lmx_steepener.sv
module test_lmx_steepener;
  localparam int DW = 8, CW = 8, KW = 6, LWW = 6, TW = 10, CTW = 11;

  logic clk = 0, rst_n = 0, in_valid = 0, wide_sel = 1;
  logic [DW-1:0] y_in = 0;
  logic [CW-1:0] u_in = 0, v_in = 0;
  logic [KW-1:0] steep = 63;
  logic [LWW-1:0] line_width = 32;
  logic [TW-1:0] thresh = 0;
  logic out_valid;
  logic [DW-1:0] y_out, env_out;
  logic [CW-1:0] u_out, v_out;
  logic signed [CTW-1:0] peak_contour;

  always #4 clk = ~clk;

  lmx_steepener i_lmx_steepener (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .y_in(y_in),
    .u_in(u_in), .v_in(v_in), .wide_sel(wide_sel), .steep(steep),
    .line_width(line_width), .thresh(thresh), .out_valid(out_valid),
    .y_out(y_out), .u_out(u_out), .v_out(v_out), .env_out(env_out),
    .peak_contour(peak_contour)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int hy [5];
  int hu [5];
  int hv [5];
  int q_y[$], q_env[$], q_pk[$], q_u[$], q_v[$], q_cyc[$];
  int last_y = 0;
  int zero_hits = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  function automatic int floor_div64(int num);
    if (num >= 0) return num / 64;
    return -((-num + 63) / 64);
  endfunction

  // bench model, restated from the requirements
  task automatic push(int y, int u, int v);
    int mn, mx, c, d, nar, e, tgt, k, yexp;
    for (int i = 4; i > 0; i--) begin
      hy[i] = hy[i-1]; hu[i] = hu[i-1]; hv[i] = hv[i-1];
    end
    hy[0] = y; hu[0] = u; hv[0] = v;
    mn = 255; mx = 0;
    for (int i = 0; i < 5; i++) begin
      if (hy[i] < mn) mn = hy[i];
      if (hy[i] > mx) mx = hy[i];
    end
    c   = hy[2];
    d   = c + c - hy[0] - hy[4];
    nar = c + c - hy[1] - hy[3];
    e   = d + int'(line_width) - 32;
    if (e == 0 && int'(thresh) == 0) zero_hits++;
    if ((d < 0 ? -d : d) < int'(thresh)) tgt = c;
    else if (e > 0) tgt = mx;
    else if (e < 0) tgt = mn;
    else tgt = c;
    k = (steep == 63) ? 64 : int'(steep);
    yexp = c + floor_div64((tgt - c) * k);
    q_y.push_back(yexp);
    q_env.push_back(mx - mn);
    q_pk.push_back(wide_sel ? d : nar);
    q_u.push_back(hu[2]);
    q_v.push_back(hv[2]);
    q_cyc.push_back(cyc);
    in_valid = 1; y_in = DW'(y); u_in = CW'(u); v_in = CW'(v);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] step_lfsr(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (q_y.size() == 0) begin
          check("R1 spurious out_valid", 1, 0);
        end else begin
          check("R1 latency", cyc - q_cyc.pop_front(), 2);
          check("R4/R5/R6 y_out", int'(y_out), q_y.pop_front());
          check("R3 env_out", int'(env_out), q_env.pop_front());
          check("R7 peak_contour", int'(peak_contour), q_pk.pop_front());
          check("R8 u_out", int'(u_out), q_u.pop_front());
          check("R8 v_out", int'(v_out), q_v.pop_front());
        end
        last_y = int'(y_out);
      end else begin
        check("R1 hold y_out", int'(y_out), last_y);
      end
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin hy[i] = 0; hu[i] = 0; hv[i] = 0; end
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    check("R9 out_valid", int'(out_valid), 0);
    check("R9 y_out", int'(y_out), 0);
    check("R9 env_out", int'(env_out), 0);
    check("R9 peak_contour", int'(peak_contour), 0);
    check("R9 u_out", int'(u_out), 0);

    // R2: priming from zero, then a rising step and an impulse
    for (int i = 0; i < 6; i++) push(16, 1, 2);
    for (int i = 0; i < 6; i++) push(240, 3, 4);
    for (int i = 0; i < 4; i++) push(16, 5, 6);
    push(200, 7, 8);
    for (int i = 0; i < 5; i++) push(16, 9, 10);
    idle(4);

    // R10: same pattern spread with long gaps
    for (int i = 0; i < 12; i++) begin
      push((i >= 5) ? 230 : 20, i, 255 - i);
      idle(i % 4);
    end
    idle(4);

    // R4 R5 R6 R7 sweep over controls with pseudo-random bursts
    for (int lw = 0; lw < 64; lw += 7) begin
      for (int si = 0; si < 4; si++) begin
        for (int ti = 0; ti < 3; ti++) begin
          for (int ws = 0; ws < 2; ws++) begin
            line_width = LWW'(lw);
            steep = (si == 0) ? 6'd0 : (si == 1) ? 6'd1 : (si == 2) ? 6'd33 : 6'd63;
            thresh = (ti == 0) ? 10'd0 : (ti == 1) ? 10'd24 : 10'd300;
            wide_sel = ws[0];
            for (int n = 0; n < 10; n++) begin
              lfsr = step_lfsr(lfsr);
              if (n == 4 && ti == 0) push(32 - lw + 64, n, n);
              else push(int'(lfsr[7:0]), int'(lfsr[15:8]), int'(lfsr[11:4]));
              if (lfsr[3]) idle(int'(lfsr[2:1]));
            end
            idle(4);
          end
        end
      end
    end

    // R4: exact zero biased contour, flat window then cancel bias
    thresh = 0; steep = 63; wide_sel = 1;
    for (int lw = 28; lw <= 36; lw++) begin
      line_width = LWW'(lw);
      push(100, 0, 0); push(100, 0, 0);
      push(100 + ((32 - lw) / 2), 0, 0);
      push(100, 0, 0); push(100 + (((32 - lw) % 2 != 0) ? -(32 - lw) % 2 : 0), 0, 0);
      push(100, 0, 0);
      idle(4);
    end
    idle(4);
    check("R4 zero-contour cases reached", (zero_hits > 0) ? 1 : 0, 1);
    check("R1 queue drained", q_y.size(), 0);
    finish_run();
  end
endmodule